// File: doc/BRIEF.md
# Dual-View Floating-Point Register Bank

This block is the register storage behind a floating-point unit that can see its registers in two ways. It keeps a fixed number of 64-bit physical entries. The entries are reached through a 32-bit single-precision view and a 64-bit double-precision view. Each view has two combinational read ports and one clocked write port.

A mode input chooses how register numbers reach storage. In paired mode, two single-precision registers share one 64-bit entry, and odd and even double-precision numbers alias the same entry. In flat mode, every register number owns its own entry. The mode can change at any time. Changing it only changes how the existing contents are viewed.

The block works out the entry and the 32-bit half for each access. On a single-precision write it merges the 32-bit data into the 64-bit entry. When a single write and a double write hit the same entry in the same cycle, it resolves the conflict. Arithmetic, control registers and rounding belong to other blocks.

Top module: `fpr_bank`

## Requirements
- R1: While reset is asserted, and until the first write after it, every entry reads as zero through every port in both modes.
- R2: With `wide_mode` = 0, single-precision register n uses entry n>>1. Bit 0 of n picks the half: 0 selects bits 31:0 and 1 selects bits 63:32.
- R3: With `wide_mode` = 0, double-precision register n reads and writes the whole of entry n>>1, so registers 2k and 2k+1 return the same 64-bit value.
- R4: With `wide_mode` = 1, single-precision register n uses bits 31:0 of entry n.
- R5: With `wide_mode` = 1, double-precision register n reads and writes the whole of entry n.
- R6: A single-precision write changes only its selected 32-bit half. The other half of the entry keeps its value.
- R7: A write takes effect at the rising clock edge. During the write cycle, reads return the value held before that edge, with no bypass. Entries that no write targets keep their values.
- R8: When a single-precision write and a double-precision write target the same entry in the same cycle, the entry afterwards holds exactly the double-precision data. Writes to different entries in the same cycle both land.
- R9: The two read ports of each precision take independent register numbers and return their data in the same cycle.
- R10: Changing `wide_mode` alters no stored bit. Data written in one mode reads back in the other mode at the location the mapping rules give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| wide_mode | input | 1 | 0 = paired mapping, 1 = flat mapping |
| sp_rd_a_idx | input | 5 | Single-precision read port A register number |
| sp_rd_a_data | output | 32 | Single-precision read port A data |
| sp_rd_b_idx | input | 5 | Single-precision read port B register number |
| sp_rd_b_data | output | 32 | Single-precision read port B data |
| dp_rd_a_idx | input | 5 | Double-precision read port A register number |
| dp_rd_a_data | output | 64 | Double-precision read port A data |
| dp_rd_b_idx | input | 5 | Double-precision read port B register number |
| dp_rd_b_data | output | 64 | Double-precision read port B data |
| sp_we | input | 1 | Single-precision write enable |
| sp_wr_idx | input | 5 | Single-precision write register number |
| sp_wr_data | input | 32 | Single-precision write data |
| dp_we | input | 1 | Double-precision write enable |
| dp_wr_idx | input | 5 | Double-precision write register number |
| dp_wr_data | input | 64 | Double-precision write data |

## Verification
The bench builds the block with its defaults: 32 entries of 64 bits. At that size, register numbers 0 and 31 are both reachable, as are neighbouring even/odd pairs that fold onto one entry in paired mode and split apart in flat mode. The tests switch the mode with live data in storage, which shows the same bits seen both ways. Collision tests place a single-precision and a double-precision write on one entry in the same cycle, and also on two different entries.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int FPR_DEF_REGS  = 32;
    localparam int FPR_DEF_WIDTH = 64;

    // How register numbers reach physical entries
    typedef enum logic {
        MAP_PAIRED = 1'b0,
        MAP_FLAT   = 1'b1
    } fpr_map_e;

    // Half used by a single-precision access: 1 = upper half
    function automatic logic pick_half(fpr_map_e mode, logic idx_lsb);
        return (mode == MAP_PAIRED) ? idx_lsb : 1'b0;
    endfunction

endpackage

// File: rtl/fpr_addr_map.sv
module fpr_addr_map
    import fpr_pkg::*;
#(
    parameter int NUM_REGS = FPR_DEF_REGS,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  fpr_map_e           mode,
    input  logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   entry
);

    always_comb begin
        case (mode)
            MAP_PAIRED: entry = {1'b0, idx[IDX_W-1:1]};
            MAP_FLAT:   entry = idx;
            default:    entry = idx;
        endcase
    end

endmodule

// File: rtl/fpr_read_lane.sv
module fpr_read_lane
    import fpr_pkg::*;
#(
    parameter int NUM_REGS = FPR_DEF_REGS,
    parameter int REG_W    = FPR_DEF_WIDTH,
    parameter int OUT_W    = FPR_DEF_WIDTH,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][REG_W-1:0] mem,
    input  fpr_map_e                       mode,
    input  logic [IDX_W-1:0]               idx,
    output logic [OUT_W-1:0]               rd_data
);

    logic [IDX_W-1:0] entry;
    logic [REG_W-1:0] word;

    fpr_addr_map #(.NUM_REGS(NUM_REGS)) u_map (
        .mode  (mode),
        .idx   (idx),
        .entry (entry)
    );

    assign word = mem[entry];

    generate
        if (OUT_W == REG_W) begin : g_full
            assign rd_data = word;
        end else begin : g_half
            logic upper;
            assign upper   = pick_half(mode, idx[0]);
            assign rd_data = upper ? word[REG_W-1 -: OUT_W] : word[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fpr_store.sv
module fpr_store
    import fpr_pkg::*;
#(
    parameter int NUM_REGS = FPR_DEF_REGS,
    parameter int REG_W    = FPR_DEF_WIDTH,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int HALF_W  = REG_W / 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sp_we,
    input  logic [IDX_W-1:0]               sp_entry,
    input  logic                           sp_upper,
    input  logic [HALF_W-1:0]              sp_data,
    input  logic                           dp_we,
    input  logic [IDX_W-1:0]               dp_entry,
    input  logic [REG_W-1:0]               dp_data,
    output logic [NUM_REGS-1:0][REG_W-1:0] mem
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] ent;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_REGS-1:0] sp_hit, dp_hit;

    generate
        for (genvar e = 0; e < NUM_REGS; e++) begin : g_hit
            assign sp_hit[e] = sp_we && (sp_entry == IDX_W'(e));
            assign dp_hit[e] = dp_we && (dp_entry == IDX_W'(e));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < NUM_REGS; e++) begin
            if (dp_hit[e]) begin
                st_d.ent[e] = dp_data;
            end else if (sp_hit[e]) begin
                if (sp_upper) st_d.ent[e][REG_W-1:HALF_W] = sp_data;
                else          st_d.ent[e][HALF_W-1:0]     = sp_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem = st_q.ent;

    generate
        for (genvar e = 0; e < NUM_REGS; e++) begin : g_chk
            // R1
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |-> st_q.ent[e] == '0);
            // R8
            dp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dp_hit[e] |=> st_q.ent[e] == $past(dp_data));
            // R6
            keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sp_hit[e] && !dp_hit[e] && !sp_upper) |=> $stable(st_q.ent[e][REG_W-1:HALF_W]));
            // R6
            keep_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sp_hit[e] && !dp_hit[e] && sp_upper) |=> $stable(st_q.ent[e][HALF_W-1:0]));
            // R7
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!sp_hit[e] && !dp_hit[e]) |=> $stable(st_q.ent[e]));
        end
    endgenerate

endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
    import fpr_pkg::*;
#(
    parameter int NUM_REGS = FPR_DEF_REGS,
    parameter int REG_W    = FPR_DEF_WIDTH,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int HALF_W  = REG_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [IDX_W-1:0]  sp_rd_a_idx,
    output logic [HALF_W-1:0] sp_rd_a_data,
    input  logic [IDX_W-1:0]  sp_rd_b_idx,
    output logic [HALF_W-1:0] sp_rd_b_data,
    input  logic [IDX_W-1:0]  dp_rd_a_idx,
    output logic [REG_W-1:0]  dp_rd_a_data,
    input  logic [IDX_W-1:0]  dp_rd_b_idx,
    output logic [REG_W-1:0]  dp_rd_b_data,
    input  logic              sp_we,
    input  logic [IDX_W-1:0]  sp_wr_idx,
    input  logic [HALF_W-1:0] sp_wr_data,
    input  logic              dp_we,
    input  logic [IDX_W-1:0]  dp_wr_idx,
    input  logic [REG_W-1:0]  dp_wr_data
);

    fpr_map_e map_mode;
    assign map_mode = fpr_map_e'(wide_mode);

    logic [NUM_REGS-1:0][REG_W-1:0] mem;
    logic [IDX_W-1:0] sp_wr_entry, dp_wr_entry;
    logic             sp_wr_upper;

    fpr_addr_map #(.NUM_REGS(NUM_REGS)) u_sp_wmap (
        .mode (map_mode), .idx (sp_wr_idx), .entry (sp_wr_entry));
    fpr_addr_map #(.NUM_REGS(NUM_REGS)) u_dp_wmap (
        .mode (map_mode), .idx (dp_wr_idx), .entry (dp_wr_entry));

    assign sp_wr_upper = pick_half(map_mode, sp_wr_idx[0]);

    fpr_store #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sp_we    (sp_we),
        .sp_entry (sp_wr_entry),
        .sp_upper (sp_wr_upper),
        .sp_data  (sp_wr_data),
        .dp_we    (dp_we),
        .dp_entry (dp_wr_entry),
        .dp_data  (dp_wr_data),
        .mem      (mem)
    );

    fpr_read_lane #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .OUT_W(HALF_W)) u_sp_ra (
        .mem (mem), .mode (map_mode), .idx (sp_rd_a_idx), .rd_data (sp_rd_a_data));
    fpr_read_lane #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .OUT_W(HALF_W)) u_sp_rb (
        .mem (mem), .mode (map_mode), .idx (sp_rd_b_idx), .rd_data (sp_rd_b_data));
    fpr_read_lane #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .OUT_W(REG_W)) u_dp_ra (
        .mem (mem), .mode (map_mode), .idx (dp_rd_a_idx), .rd_data (dp_rd_a_data));
    fpr_read_lane #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .OUT_W(REG_W)) u_dp_rb (
        .mem (mem), .mode (map_mode), .idx (dp_rd_b_idx), .rd_data (dp_rd_b_data));

    // R2
    paired_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && sp_rd_a_idx == dp_rd_a_idx) |->
        sp_rd_a_data == (sp_rd_a_idx[0] ? dp_rd_a_data[REG_W-1:HALF_W]
                                        : dp_rd_a_data[HALF_W-1:0]));
    // R4
    flat_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && sp_rd_b_idx == dp_rd_b_idx) |->
        sp_rd_b_data == dp_rd_b_data[HALF_W-1:0]);
    // R3
    dp_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && dp_rd_a_idx[IDX_W-1:1] == dp_rd_b_idx[IDX_W-1:1]) |->
        dp_rd_a_data == dp_rd_b_data);

endmodule

// File: tb/tb_fpr_bank.sv
module tb_fpr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [4:0]  sp_rd_a_idx = '0, sp_rd_b_idx = '0, dp_rd_a_idx = '0, dp_rd_b_idx = '0;
    logic [31:0] sp_rd_a_data, sp_rd_b_data;
    logic [63:0] dp_rd_a_data, dp_rd_b_data;
    logic        sp_we = 1'b0, dp_we = 1'b0;
    logic [4:0]  sp_wr_idx = '0, dp_wr_idx = '0;
    logic [31:0] sp_wr_data = '0;
    logic [63:0] dp_wr_data = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [63:0] model [32];

    always #4 clk = ~clk;

    fpr_bank dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .sp_rd_a_idx(sp_rd_a_idx), .sp_rd_a_data(sp_rd_a_data),
        .sp_rd_b_idx(sp_rd_b_idx), .sp_rd_b_data(sp_rd_b_data),
        .dp_rd_a_idx(dp_rd_a_idx), .dp_rd_a_data(dp_rd_a_data),
        .dp_rd_b_idx(dp_rd_b_idx), .dp_rd_b_data(dp_rd_b_data),
        .sp_we(sp_we), .sp_wr_idx(sp_wr_idx), .sp_wr_data(sp_wr_data),
        .dp_we(dp_we), .dp_wr_idx(dp_wr_idx), .dp_wr_data(dp_wr_data)
    );

    function automatic logic [31:0] exp_sp(logic [4:0] idx);
        if (wide_mode) return model[idx][31:0];
        return idx[0] ? model[idx >> 1][63:32] : model[idx >> 1][31:0];
    endfunction

    function automatic logic [63:0] exp_dp(logic [4:0] idx);
        return wide_mode ? model[idx] : model[idx >> 1];
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one cycle of writes; model updated afterwards (single first, double wins)
    task automatic do_write(bit s_en, logic [4:0] s_idx, logic [31:0] s_dat,
                            bit d_en, logic [4:0] d_idx, logic [63:0] d_dat);
        @(negedge clk);
        sp_we = s_en; sp_wr_idx = s_idx; sp_wr_data = s_dat;
        dp_we = d_en; dp_wr_idx = d_idx; dp_wr_data = d_dat;
        @(negedge clk);
        sp_we = 1'b0; dp_we = 1'b0;
        if (s_en) begin
            if (wide_mode)     model[s_idx][31:0]       = s_dat;
            else if (s_idx[0]) model[s_idx >> 1][63:32] = s_dat;
            else               model[s_idx >> 1][31:0]  = s_dat;
        end
        if (d_en) begin
            if (wide_mode) model[d_idx] = d_dat;
            else           model[d_idx >> 1] = d_dat;
        end
    endtask

    task automatic look(string req, logic [4:0] sa, logic [4:0] sb,
                        logic [4:0] da, logic [4:0] db);
        sp_rd_a_idx = sa; sp_rd_b_idx = sb; dp_rd_a_idx = da; dp_rd_b_idx = db;
        #1;
        chk(req, {32'h0, sp_rd_a_data}, {32'h0, exp_sp(sa)});
        chk(req, {32'h0, sp_rd_b_data}, {32'h0, exp_sp(sb)});
        chk(req, dp_rd_a_data, exp_dp(da));
        chk(req, dp_rd_b_data, exp_dp(db));
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            wide_mode = m[0];
            for (int i = 0; i < 32; i++)
                look("R1 reset", 5'(i), 5'(31 - i), 5'(i), 5'(31 - i));
        end
        wide_mode = 1'b0;
    endtask

    task automatic t_paired_pack();
        wide_mode = 1'b0;
        do_write(1, 5'd4, 32'hAAAA_0004, 0, 0, 0);
        do_write(1, 5'd5, 32'hBBBB_0005, 0, 0, 0);
        look("R2 paired single", 5'd4, 5'd5, 5'd4, 5'd5);
        chk("R3 paired double alias", dp_rd_a_data, 64'hBBBB_0005_AAAA_0004);
        chk("R3 paired double alias odd", dp_rd_b_data, 64'hBBBB_0005_AAAA_0004);
        chk("R9 two single ports", {sp_rd_b_data, sp_rd_a_data}, 64'hBBBB_0005_AAAA_0004);
        do_write(1, 5'd31, 32'hCAFE_001F, 0, 0, 0);
        look("R2 top register", 5'd31, 5'd30, 5'd31, 5'd0);
        chk("R2 upper half of last entry", dp_rd_a_data, 64'hCAFE_001F_0000_0000);
    endtask

    task automatic t_half_keep();
        wide_mode = 1'b0;
        do_write(1, 5'd7, 32'h1111_0007, 0, 0, 0);
        do_write(1, 5'd6, 32'h2222_0006, 0, 0, 0);
        look("R6 upper kept", 5'd6, 5'd7, 5'd6, 5'd7);
        chk("R6 merged entry", dp_rd_a_data, 64'h1111_0007_2222_0006);
        do_write(1, 5'd7, 32'h3333_0007, 0, 0, 0);
        look("R6 lower kept", 5'd6, 5'd7, 5'd6, 5'd2);
        chk("R6 lower kept after upper write", {32'h0, sp_rd_a_data}, 64'h2222_0006);
    endtask

    task automatic t_wide_view();
        wide_mode = 1'b1;
        look("R10 flat view of paired data", 5'd2, 5'd3, 5'd2, 5'd4);
        chk("R10 entry 2 unchanged", dp_rd_a_data, 64'hBBBB_0005_AAAA_0004);
        chk("R4 flat single low half", {32'h0, sp_rd_a_data}, 64'hAAAA_0004);
        chk("R5 flat double own entry", dp_rd_b_data, 64'h0);
        do_write(0, 0, 0, 1, 5'd9, 64'h9999_8888_7777_6666);
        look("R5 flat double write", 5'd9, 5'd8, 5'd9, 5'd8);
        chk("R5 flat double value", dp_rd_a_data, 64'h9999_8888_7777_6666);
        do_write(1, 5'd9, 32'h5555_0009, 0, 0, 0);
        look("R4 flat single write", 5'd9, 5'd9, 5'd9, 5'd4);
        chk("R4 R6 flat merge", dp_rd_a_data, 64'h9999_8888_5555_0009);
        wide_mode = 1'b0;
        look("R10 paired view of flat data", 5'd18, 5'd19, 5'd18, 5'd19);
        chk("R10 entry 9 as pair", dp_rd_b_data, 64'h9999_8888_5555_0009);
    endtask

    task automatic t_no_bypass();
        wide_mode = 1'b1;
        @(negedge clk);
        dp_rd_a_idx = 5'd1; sp_rd_a_idx = 5'd1;
        dp_we = 1'b1; dp_wr_idx = 5'd1; dp_wr_data = 64'hDEAD_BEEF_0123_4567;
        #1;
        chk("R7 no bypass double", dp_rd_a_data, model[1]);
        chk("R7 no bypass single", {32'h0, sp_rd_a_data}, {32'h0, model[1][31:0]});
        @(negedge clk);
        dp_we = 1'b0;
        model[1] = 64'hDEAD_BEEF_0123_4567;
        #1;
        chk("R7 visible after edge", dp_rd_a_data, 64'hDEAD_BEEF_0123_4567);
        look("R7 other entries held", 5'd0, 5'd2, 5'd0, 5'd2);
    endtask

    task automatic t_collide();
        wide_mode = 1'b0;
        do_write(1, 5'd10, 32'hF0F0_F0F0, 1, 5'd11, 64'h0123_4567_89AB_CDEF);
        look("R8 same entry double wins", 5'd10, 5'd11, 5'd10, 5'd11);
        chk("R8 entry 5 value", dp_rd_a_data, 64'h0123_4567_89AB_CDEF);
        do_write(1, 5'd12, 32'h1234_5678, 1, 5'd20, 64'hAAAA_BBBB_CCCC_DDDD);
        look("R8 distinct entries both land", 5'd12, 5'd21, 5'd12, 5'd20);
        chk("R8 single landed", {32'h0, sp_rd_a_data}, 64'h1234_5678);
        chk("R8 double landed", dp_rd_b_data, 64'hAAAA_BBBB_CCCC_DDDD);
        wide_mode = 1'b1;
        do_write(1, 5'd3, 32'h7777_7777, 1, 5'd3, 64'h1357_9BDF_2468_ACE0);
        look("R8 flat collision", 5'd3, 5'd0, 5'd3, 5'd1);
        chk("R8 flat double wins", dp_rd_a_data, 64'h1357_9BDF_2468_ACE0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_paired_pack();
        t_half_keep();
        t_wide_view();
        t_no_bypass();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule